// File: doc/BRIEF.md
# Dual-Plane Blinking Seven-Segment Scanner

This block drives a multiplexed seven-segment display of up to eight digits. A host writes 16-bit commands over a three-wire serial port made of an active-low select, a shift clock and a data line. The upper byte of each command is an address and the lower byte is data. The address selects one of four things: the configuration byte, the per-digit decode mask, the display-test flag, or the segment byte of one digit in one of two storage planes. The serial pins are sampled in the system clock domain, so the shift clock must be much slower than `clk`.

A single free-running multiplex counter does two jobs. It steps a one-hot digit select through the digits, and one of its upper bits sets the blink phase. When blinking is enabled, the displayed plane alternates between the first plane and the second plane on that phase. Configuration writes can also act on the block as a whole: one bit restarts the counter so that several scanners can be aligned, and another bit empties both planes. Each digit can show its low nibble as a hexadecimal glyph, or it can drive its raw byte straight onto the segments.

Top module: `blink_disp_ctrl`

## Requirements
- R1: Bits are shifted on rising `ser_clk` edges while `ser_cs_n` is low, most significant bit first. The command is the last 16 bits received, and extra leading bits are discarded. The command acts on the rising edge of `ser_cs_n`, with the address in bits 15:8 and the data in bits 7:0.
- R2: The address map is as follows. 0x04 is configuration. 0x01 is the decode mask, one bit per digit. 0x07 is display test, using data bit 0. 0x20+n is the first-plane byte of digit n. 0x40+n is the second-plane byte of digit n. A write to any other address changes nothing that can be seen.
- R3: The counter advances once per `clk`. The selected digit is (count/4) mod 8, so one scan lasts 32 cycles. `dig_sel` is one-hot (bit n = digit n) whenever the display is lit.
- R4: When a digit's decode bit is 1, its segments show the hexadecimal glyph of data bits 3:0 (a=bit0 … g=bit6): 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 for 0 to F. Bit 7 (the decimal point) is taken from data bit 7. When the decode bit is 0, the raw byte drives the segments.
- R5: Configuration bit 0 set to 0 means shutdown. In shutdown, `seg` and `dig_sel` are both 0 and all stored contents are kept. Writes are still accepted during shutdown.
- R6: While display test is on, every digit is scanned with `seg` = 0xFF, even in shutdown.
- R7: When blinking is disabled (configuration bit 3 = 0), only first-plane data is shown.
- R8: When blinking is enabled, the phase is count bit 6 if configuration bit 2 = 0, and count bit 7 if configuration bit 2 = 1. Phase 0 shows the first plane and phase 1 shows the second plane.
- R9: A configuration write with bit 4 = 1 clears the counter on the select rising edge.
- R10: A configuration write with bit 5 = 1 zeroes every byte of both planes. Afterwards, decoded digits show 0x3F and raw digits show 0x00.
- R11: After reset the block is in shutdown with blinking off, the decode mask at 0, test off, both planes at zero and the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in |
| seg | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |
| dig_sel | output | NDIG | One-hot digit select |

## Verification
The hardest conditions to reach from the pins are the exact counter phases, because the counter runs freely and its value is never visible. Each sweep therefore starts with a configuration write that sets the restart bit. The bench then knows the count on every following cycle. It steps through all 256 counter values, predicting the digit, plane and glyph for each one. Sweeps are repeated with blink off, fast blink, slow blink, shutdown, test and after a global clear.

// File: rtl/blink_disp_ctrl.sv
module blink_disp_ctrl #(
  parameter int NDIG   = 8,
  parameter int SLOT_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_cs_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  output logic [7:0]      seg,
  output logic [NDIG-1:0] dig_sel
);
  localparam int DIG_W = $clog2(NDIG);

  logic cs_q, cs_q1, sck_q, sck_q1, din_q;
  logic [15:0] shreg;
  logic run, slow, blink_en, test;
  logic [NDIG-1:0] dec_mask;
  logic [NDIG-1:0][7:0] p0, p1;
  logic [CNT_W-1:0] cnt;

  wire apply   = cs_q & ~cs_q1;
  wire [7:0] addr = shreg[15:8];
  wire [7:0] data = shreg[7:0];
  wire cfg_wr  = apply && (addr == 8'h04);
  wire sync    = cfg_wr & data[4];
  wire clr     = cfg_wr & data[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; cs_q1 <= 1'b1;
      sck_q <= 1'b0; sck_q1 <= 1'b0; din_q <= 1'b0;
      shreg <= '0;
    end else begin
      cs_q <= ser_cs_n; cs_q1 <= cs_q;
      sck_q <= ser_clk; sck_q1 <= sck_q; din_q <= ser_din;
      if (!cs_q && sck_q && !sck_q1) shreg <= {shreg[14:0], din_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; slow <= 1'b0; blink_en <= 1'b0; test <= 1'b0;
      dec_mask <= '0;
    end else if (apply) begin
      if (cfg_wr) begin
        run <= data[0]; slow <= data[2]; blink_en <= data[3];
      end
      if (addr == 8'h01) dec_mask <= data[NDIG-1:0];
      if (addr == 8'h07) test <= data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= '0; p1 <= '0;
    end else if (clr) begin
      p0 <= '0; p1 <= '0;
    end else if (apply) begin
      for (int i = 0; i < NDIG; i++) begin
        if (addr == 8'(32 + i)) p0[i] <= data;
        if (addr == 8'(64 + i)) p1[i] <= data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (sync) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: glyph = 7'h3F; 4'h1: glyph = 7'h06; 4'h2: glyph = 7'h5B; 4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66; 4'h5: glyph = 7'h6D; 4'h6: glyph = 7'h7D; 4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F; 4'h9: glyph = 7'h6F; 4'hA: glyph = 7'h77; 4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39; 4'hD: glyph = 7'h5E; 4'hE: glyph = 7'h79; default: glyph = 7'h71;
    endcase
  endfunction

  wire [DIG_W-1:0] idx = cnt[SLOT_W +: DIG_W];
  wire phase = slow ? cnt[CNT_W-1] : cnt[CNT_W-2];
  wire [7:0] cur = (blink_en && phase) ? p1[idx] : p0[idx];
  wire [7:0] shown = dec_mask[idx] ? {cur[7], glyph(cur[3:0])} : cur;
  wire lit = test | run;

  assign seg     = test ? 8'hFF : (run ? shown : 8'h00);
  assign dig_sel = lit ? (NDIG'(1) << idx) : '0;
endmodule

module blink_disp_ctrl_chk #(
  parameter int NDIG  = 8,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync,
  input logic                 clr,
  input logic                 run,
  input logic                 test,
  input logic [CNT_W-1:0]     cnt,
  input logic [NDIG-1:0][7:0] p0,
  input logic [NDIG-1:0][7:0] p1,
  input logic [7:0]           seg,
  input logic [NDIG-1:0]      dig_sel
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dig_sel)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !sync |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R3
  AST_SHUT_BLANK: assert property (@(posedge clk) disable iff (!rst_n) (!run && !test) |-> (dig_sel == '0 && seg == 8'h00)); // R5
  AST_TEST_LIT: assert property (@(posedge clk) disable iff (!rst_n) test |-> (seg == 8'hFF && $countones(dig_sel) == 1)); // R6
  AST_SYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n) sync |=> cnt == '0); // R9
  AST_PLANE_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (p0 == '0 && p1 == '0)); // R10
endmodule

bind blink_disp_ctrl blink_disp_ctrl_chk #(.NDIG(NDIG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .clr(clr), .run(run), .test(test),
  .cnt(cnt), .p0(p0), .p1(p1), .seg(seg), .dig_sel(dig_sel)
);

// File: tb/blink_disp_ctrl_tb.sv
module blink_disp_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [7:0] seg;
  logic [7:0] dig_sel;
  int tests = 0, fails = 0;

  blink_disp_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
                         .ser_din(ser_din), .seg(seg), .dig_sel(dig_sel));

  always #5 clk = ~clk;

  logic [7:0] font [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                            8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};
  logic [7:0] m0 [8];
  logic [7:0] m1 [8];
  logic [7:0] mdec = 8'h00;
  logic mrun = 0, mslow = 0, mblink = 0, mtest = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    @(negedge clk) ser_cs_n = 1'b0;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ser_din = w[i];
      @(negedge clk) ser_clk = 1'b1;
      @(negedge clk);
      @(negedge clk) ser_clk = 1'b0;
    end
    @(negedge clk);
    @(negedge clk) ser_cs_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    shift_bits({16'h0, a, d}, 16);
    if (a == 8'h04) begin
      mrun = d[0]; mslow = d[2]; mblink = d[3];
      if (d[5]) for (int i = 0; i < 8; i++) begin m0[i] = 0; m1[i] = 0; end
    end
    if (a == 8'h01) mdec = d;
    if (a == 8'h07) mtest = d[0];
    if (a >= 8'h20 && a < 8'h28) m0[a - 8'h20] = d;
    if (a >= 8'h40 && a < 8'h48) m1[a - 8'h40] = d;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] expect_at(input int k);
    int i; logic ph; logic [7:0] v, s;
    i = (k >> 2) & 7;
    ph = mslow ? k[7] : k[6];
    v = (mblink && ph) ? m1[i] : m0[i];
    s = mdec[i] ? {v[7], font[v[3:0]][6:0]} : v;
    if (mtest) return {8'hFF, 8'(1 << i)};
    if (!mrun) return 16'h0000;
    return {s, 8'(1 << i)};
  endfunction

  task automatic sweep(input string req, input logic [7:0] cfg);
    shift_bits({16'h0, 8'h04, cfg | 8'h10}, 16);
    mrun = cfg[0]; mslow = cfg[2]; mblink = cfg[3];
    @(posedge clk); @(posedge clk); #1;
    for (int k = 0; k < 256; k++) begin
      check(req, {seg, dig_sel}, expect_at(k));
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m0[i] = 0; m1[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset blank", {seg, dig_sel}, 16'h0000);
    sweep("R11 reset contents", 8'h01);

    for (int i = 0; i < 8; i++) begin
      wr(8'(8'h20 + i), 8'(8'h10 * i + 8'h83 - i));
      wr(8'(8'h40 + i), 8'(8'h5A ^ (i * 8'h27)));
    end
    wr(8'h01, 8'h0F);
    sweep("R4 R7 blink off", 8'h01);
    sweep("R3 R9 blink off resync", 8'h01);

    wr(8'h10, 8'hAA);
    sweep("R2 unmapped address", 8'h01);

    sweep("R8 fast blink", 8'h09);
    wr(8'h01, 8'hA5);
    sweep("R8 slow blink", 8'h0D);

    sweep("R5 shutdown blank", 8'h08);
    wr(8'h23, 8'h7E);
    wr(8'h01, 8'h3C);
    sweep("R5 written in shutdown", 8'h01);

    wr(8'h07, 8'h01);
    sweep("R6 test overrides shutdown", 8'h00);
    wr(8'h07, 8'h00);
    sweep("R6 test off", 8'h01);

    shift_bits(32'h00C3_2599, 24);
    m0[5] = 8'h99;
    repeat (3) @(negedge clk);
    sweep("R1 last 16 bits", 8'h01);

    wr(8'h01, 8'h55);
    wr(8'h04, 8'h29);
    sweep("R10 global clear", 8'h09);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule